// File: doc/BRIEF.md
# Per-Line Edge/Level Interrupt Request Latch

This block turns a group of raw interrupt request wires into a vector of pending requests. Each line is handled either as an edge source or as a level source, and a trigger-mode register holds one bit per line to pick between them. In level mode the pending bit tracks the wire. In edge mode a low-to-high transition latches a request, and the request stays latched until that line is acknowledged.

Every line remembers the level its wire had on the previous clock, in both modes. Because of this, a line that moves from level to edge mode while its wire is high does not produce a spurious request. Software updates the trigger-mode register through a byte-wide write port. A constant writable-bits mask filters each write, so lines whose mode is fixed cannot be changed. A downstream priority resolver reads the pending vector and names a line on the acknowledge input when it services that line.

The inputs are synchronous to `clk`. There is no streaming data path, so every pin is a plain control or status signal and none of them applies back-pressure.

Top module: `irq_req_latch`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `pend_o`, `mode_o` and `cfg_rdata` are all zero. A mode of zero puts every line in edge mode.
- R2: A cycle with `cfg_we` high stores `cfg_wdata & WRITE_MASK` in the mode register. The default mask is 8'hF8. The stored value appears on `mode_o` and `cfg_rdata` after that clock edge. Requests sampled on the same edge as the write still use the old mode.
- R3: For a line whose mode bit is 1 (level), the pending bit is a copy of the request input, delayed by one clock.
- R4: For a line whose mode bit is 0 (edge), the pending bit is set on the clock after the input is sampled high when it was sampled low on the clock before.
- R5: For an edge-mode line, an input that stays high, stays low or falls leaves the pending bit unchanged.
- R6: When `ack_valid` is high and `ack_line` equals the index of an edge-mode line, that line's pending bit clears on the next clock. Other lines are not affected.
- R7: An acknowledge that names a level-mode line has no effect on its pending bit, which keeps following the input.
- R8: When a rising edge and an acknowledge reach the same edge-mode line in the same cycle, the new request wins and the pending bit is 1 afterwards.
- R9: The remembered previous level is updated in both modes. A line switched from level to edge mode while its input is held high produces no new request until the input has gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Raw request lines, synchronous to clk |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data (bit i selects the mode of line i, 1 = level) |
| cfg_rdata | output | 8 | Mode register read data |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | 3 | Index of the line being acknowledged |
| pend_o | output | 8 | Pending request vector |
| mode_o | output | 8 | Trigger-mode vector |

## Verification
The hardest situation to reach from the ports is a line whose remembered level no longer matches the pending bit. This happens after a mode change or an acknowledge while the wire is held high, and it is exactly where a missed rising edge or a spurious one would show up. The stimulus gets there by writing every one of the 256 mode values in turn and driving a pseudo-random burst of request and acknowledge patterns under each. A directed sequence then holds a wire high across a level-to-edge switch and an acknowledge, and another fires a rising edge and an acknowledge on the same line in the same cycle.

// File: rtl/irql_pkg.sv
package irql_pkg;
  parameter int unsigned IRQL_LINES = 8;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irql_mode_reg.sv
module irql_mode_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mode
);
  logic [W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  mode_q <= '0;
    else if (we) mode_q <= wdata & MASK;
  end

  assign mode = mode_q;

  // A write lands filtered by the mask (R2)
  p_store_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mode == ($past(wdata) & MASK)));
  // Without a write the register holds (R2)
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mode));
endmodule

// File: rtl/irql_ack_dec.sv
module irql_ack_dec #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_valid,
  input  logic [IW-1:0] ack_line,
  output logic [W-1:0]  hit
);
  for (genvar g = 0; g < W; g++) begin : g_hit
    assign hit[g] = ack_valid && (ack_line == IW'(g));
  end

  // At most one line is acknowledged at a time (R6)
  p_single_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  // No strobe, no hit (R6)
  p_no_stray_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |-> (hit == '0));
endmodule

// File: rtl/irql_line_cell.sv
module irql_line_cell
  import irql_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  trig_e trig,
  input  logic  req,
  input  logic  ack_hit,
  output logic  pend
);
  logic pend_q, prev_q;
  logic rise;

  assign rise = req && !prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= req;
      if (trig == TRIG_LEVEL)  pend_q <= req;
      else if (rise)           pend_q <= 1'b1;
      else if (ack_hit)        pend_q <= 1'b0;
    end
  end

  assign pend = pend_q;

  // Level lines mirror the input one clock later (R3, R7)
  p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == TRIG_LEVEL) |=> (pend == $past(req)));
  // A rising edge latches a request, even beside an acknowledge (R4, R8)
  p_edge_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig == TRIG_EDGE) && req && !prev_q) |=> pend);
  // Acknowledge without a new edge clears an edge line (R6)
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig == TRIG_EDGE) && ack_hit && !(req && !prev_q)) |=> !pend);
  // Otherwise an edge line holds its request (R5)
  p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig == TRIG_EDGE) && !ack_hit && !(req && !prev_q)) |=> $stable(pend));
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irql_pkg::*;
#(
  parameter int unsigned NUM_LINES = IRQL_LINES,
  parameter logic [NUM_LINES-1:0] WRITE_MASK = 8'hF8,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 cfg_we,
  input  logic [NUM_LINES-1:0] cfg_wdata,
  output logic [NUM_LINES-1:0] cfg_rdata,
  input  logic                 ack_valid,
  input  logic [IDX_W-1:0]     ack_line,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] mode_o
);
  logic [NUM_LINES-1:0] mode;
  logic [NUM_LINES-1:0] hit;

  irql_mode_reg #(.W(NUM_LINES), .MASK(WRITE_MASK)) u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .mode  (mode)
  );

  irql_ack_dec #(.W(NUM_LINES), .IW(IDX_W)) u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_valid (ack_valid),
    .ack_line  (ack_line),
    .hit       (hit)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    irql_line_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (trig_e'(mode[i])),
      .req     (irq_in[i]),
      .ack_hit (hit[i]),
      .pend    (pend_o[i])
    );
  end

  assign mode_o    = mode;
  assign cfg_rdata = mode;

  // Fixed-mode lines never leave edge mode (R2)
  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o & ~WRITE_MASK) == '0);
  // Read port and mode vector agree (R2)
  p_read_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata == mode_o);
endmodule

// File: tb/irq_req_latch_tb.sv
module irq_req_latch_tb;
  localparam logic [7:0] MASK = 8'hF8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       ack_valid;
  logic [2:0] ack_line;
  logic [7:0] pend_o;
  logic [7:0] mode_o;

  always #4 clk = ~clk;

  irq_req_latch u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ack_valid(ack_valid),
    .ack_line(ack_line), .pend_o(pend_o), .mode_o(mode_o)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0]  m_pend, m_prev, m_mode;
  logic [31:0] seed = 32'h1F2E_3D4C;

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string bit_tag(int i, logic [7:0] inv, logic av, logic [2:0] al);
    logic hit, rise;
    hit  = av && (al == 3'(i));
    rise = inv[i] && !m_prev[i];
    if (m_mode[i]) return hit ? "R7" : "R3";
    if (hit && rise) return "R8";
    if (hit) return "R6";
    return rise ? "R4" : "R5";
  endfunction

  task automatic step(input logic [7:0] inv, input logic av, input logic [2:0] al,
                      input logic we, input logic [7:0] wd);
    string tags [8];
    for (int i = 0; i < 8; i++) tags[i] = bit_tag(i, inv, av, al);
    irq_in = inv; ack_valid = av; ack_line = al; cfg_we = we; cfg_wdata = wd;
    @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      if (m_mode[i]) m_pend[i] = inv[i];
      else if (inv[i] && !m_prev[i]) m_pend[i] = 1'b1;
      else if (av && al == 3'(i)) m_pend[i] = 1'b0;
    end
    m_prev = inv;
    if (we) m_mode = wd & MASK;
    @(negedge clk);
    for (int i = 0; i < 8; i++)
      chk(tags[i], $sformatf("pend line %0d", i), {7'b0, pend_o[i]}, {7'b0, m_pend[i]});
    chk("R2", "mode_o", mode_o, m_mode);
    chk("R2", "cfg_rdata", cfg_rdata, m_mode);
  endtask

  function automatic logic [31:0] next_rand(logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    #(8 * 190000);
    errors++;
    checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; cfg_we = 1'b0; cfg_wdata = '0;
    ack_valid = 1'b0; ack_line = '0;
    m_pend = '0; m_prev = '0; m_mode = '0;
    repeat (3) @(negedge clk);
    chk("R1", "pend in reset", pend_o, 8'h00);
    chk("R1", "mode in reset", mode_o, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pend after reset", pend_o, 8'h00);
    chk("R1", "mode after reset", mode_o, 8'h00);
    chk("R1", "rdata after reset", cfg_rdata, 8'h00);

    // R2: every write value, masked readback
    for (int v = 0; v < 256; v++) begin
      step(8'h00, 1'b0, 3'd0, 1'b1, 8'(v));
      chk("R2", "masked write", cfg_rdata, 8'(v) & MASK);
    end

    // R2: write and request on the same edge use the old (level) mode of line 7
    step(8'h80, 1'b0, 3'd0, 1'b1, 8'h00);
    chk("R2", "old mode on write edge", {7'b0, pend_o[7]}, 8'h01);
    step(8'h80, 1'b0, 3'd0, 1'b0, 8'h00);
    step(8'h00, 1'b1, 3'd7, 1'b0, 8'h00);
    chk("R6", "ack after mode switch", {7'b0, pend_o[7]}, 8'h00);

    // Sweep all mode values with pseudo-random requests and acknowledges
    for (int mi = 0; mi < 256; mi++) begin
      step(m_prev, 1'b0, 3'd0, 1'b1, 8'(mi));
      for (int k = 0; k < 40; k++) begin
        seed = next_rand(seed);
        step(seed[7:0], seed[8] | seed[9], seed[12:10], 1'b0, 8'h00);
      end
    end

    // R8: rising edge and acknowledge in the same cycle, edge mode everywhere
    step(8'h00, 1'b1, 3'd4, 1'b1, 8'h00);
    step(8'h00, 1'b1, 3'd4, 1'b0, 8'h00);
    step(8'h10, 1'b1, 3'd4, 1'b0, 8'h00);
    chk("R8", "edge beats ack", {7'b0, pend_o[4]}, 8'h01);
    step(8'h10, 1'b1, 3'd4, 1'b0, 8'h00);
    chk("R6", "ack while held high", {7'b0, pend_o[4]}, 8'h00);
    step(8'h10, 1'b0, 3'd0, 1'b0, 8'h00);
    chk("R5", "held high no re-set", {7'b0, pend_o[4]}, 8'h00);

    // R9: level to edge switch while the wire stays high
    step(8'h40, 1'b0, 3'd0, 1'b1, 8'h40);
    step(8'h40, 1'b0, 3'd0, 1'b0, 8'h00);
    chk("R3", "level pend high", {7'b0, pend_o[6]}, 8'h01);
    step(8'h40, 1'b1, 3'd6, 1'b1, 8'h00);
    chk("R7", "ack on level line", {7'b0, pend_o[6]}, 8'h01);
    step(8'h40, 1'b1, 3'd6, 1'b0, 8'h00);
    chk("R6", "ack clears after switch", {7'b0, pend_o[6]}, 8'h00);
    for (int k = 0; k < 3; k++) step(8'h40, 1'b0, 3'd0, 1'b0, 8'h00);
    chk("R9", "no spurious edge", {7'b0, pend_o[6]}, 8'h00);
    step(8'h00, 1'b0, 3'd0, 1'b0, 8'h00);
    chk("R5", "fall keeps clear", {7'b0, pend_o[6]}, 8'h00);
    step(8'h40, 1'b0, 3'd0, 1'b0, 8'h00);
    chk("R9", "fresh edge latches", {7'b0, pend_o[6]}, 8'h01);
    chk("R4", "fresh edge latches", {7'b0, pend_o[6]}, 8'h01);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule